// File: doc/BRIEF.md
# Nixie Cathode Frame Serializer

This block turns a set of four-bit digit codes, one per ten-cathode display tube, into a one-hot cathode frame. It then shifts the frame out to an external chain of serial-in, parallel-out shift registers. The frame is forty bits for the default four tubes. Bits move out on a serial clock and data line, and a latch pulse then transfers the shifted word to the register outputs. Alongside the frame, the block drives one power-enable line per tube, so a blanked tube is both dark and unpowered.

The digit source presents its codes and raises a load strobe for one cycle. The block captures the codes only while it is idle and holds a busy flag until the latch pulse has ended. Strobes that arrive while busy is high are dropped, so a frame is never cut short. The tube enables change on the cycle the latch pulse begins, which keeps them in step with the cathode pattern that appears on the external registers.

Top module: `nixie_frame_serializer`

## Requirements
- R1: Tube k takes its code from `digits_i[4k+3:4k]` and occupies frame bits `FRAME_W-1-10k` down to `FRAME_W-10-10k`, so tube 0 owns bits 39..30 of the 40-bit default frame.
- R2: Inside a tube's ten-bit field, code 0 sets the field's top bit (bit 9) and code n in 1..9 sets field bit n-1; exactly one bit is set.
- R3: Code 10 is the blank code: its field is all zeros and that tube's enable in `tube_en_o` is low.
- R4: Codes 11 to 15 are displayed as digit 0 (field bit 9 set) and their tube's enable is high.
- R5: `tube_en_o[k]` is high for every non-blank tube of the accepted frame. It changes only on the cycle `latch_o` rises and keeps its old value while the frame is still being shifted.
- R6: The frame leaves on `sdo_o` highest bit first (bit 39 first), exactly `FRAME_W` bits per frame, each valid at the rising edge of `sclk_o`; `sdo_o` changes only while `sclk_o` is low.
- R7: `sclk_o` has a period of `CLK_DIV` system cycles and is high for `CLK_DIV/2` of them; it stays low whenever no frame is being shifted.
- R8: After the last bit's clock period, `latch_o` is high for exactly `CLK_DIV` system cycles, during which `sclk_o` stays low.
- R9: A load accepted while idle raises `busy_o` on the next cycle. `busy_o` then stays high for `(FRAME_W+1)*CLK_DIV` cycles, and a load strobe raised while busy is ignored.
- R10: Synchronous reset clears the frame, holds `sclk_o`, `sdo_o`, `latch_o` and `busy_o` low, and deasserts every tube enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle strobe that offers a new set of digit codes |
| digits_i | input | NUM_TUBES*4 | Digit codes, tube k in bits 4k+3..4k |
| sclk_o | output | 1 | Serial clock to the shift-register chain |
| sdo_o | output | 1 | Serial data, highest frame bit first |
| latch_o | output | 1 | Storage latch pulse after the last bit |
| tube_en_o | output | NUM_TUBES | Per-tube power enable, low for blanked tubes |
| busy_o | output | 1 | High while a frame is being shifted or latched |

## Verification
The bench builds the block with four tubes and `CLK_DIV` set to 4 rather than 16. This shortens each frame to 164 cycles, so many frames fit in the run: every digit value, the blank code, all the out-of-range codes, an all-blank frame and back-to-back loads. With the shorter divider, the bench can count exact high-time, latch-width and busy-width totals per frame and compare them with values derived from the divider. It can also inject a load in the middle of a shift and confirm that neither the serial stream nor the enables are disturbed.

// File: rtl/nixie_pkg.sv
package nixie_pkg;

    localparam int CODE_W     = 4;
    localparam int CATHODES   = 10;
    localparam logic [CODE_W-1:0] BLANK_CODE = 4'd10;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_LATCH = 2'd2
    } ser_state_e;

    // One-hot cathode field for one tube: 0 at the top bit, n at bit n-1,
    // blank clears the field, out-of-range codes fall back to 0.
    function automatic logic [CATHODES-1:0] cathode_field(input logic [CODE_W-1:0] code);
        logic [CATHODES-1:0] fld;
        fld = '0;
        if (code == BLANK_CODE) begin
            fld = '0;
        end else if ((code == '0) || (code > CODE_W'(CATHODES-1))) begin
            fld[CATHODES-1] = 1'b1;
        end else begin
            fld = CATHODES'(1) << (code - CODE_W'(1));
        end
        return fld;
    endfunction

endpackage

// File: rtl/nixie_frame_enc.sv
module nixie_frame_enc
    import nixie_pkg::*;
#(
    parameter int NUM_TUBES = 4
) (
    input  logic [NUM_TUBES*CODE_W-1:0]   digits,
    output logic [NUM_TUBES*CATHODES-1:0] frame,
    output logic [NUM_TUBES-1:0]          tube_on
);
    localparam int FRAME_W = NUM_TUBES * CATHODES;

    for (genvar g = 0; g < NUM_TUBES; g++) begin : g_tube
        logic [CODE_W-1:0] code;
        assign code = digits[g*CODE_W +: CODE_W];
        assign frame[FRAME_W-1-g*CATHODES -: CATHODES] = cathode_field(code);
        assign tube_on[g] = (code != BLANK_CODE);
    end

endmodule

// File: rtl/nixie_sclk_gen.sv
module nixie_sclk_gen #(
    parameter int CLK_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic gate,
    output logic sclk,
    output logic period_end
);
    localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(CLK_DIV / 2);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    assign sclk       = run && gate && (phase >= PH_HALF);
    assign period_end = run && (phase == PH_LAST);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |-> !sclk) else $error("serial clock active while stopped"); // R7

endmodule

// File: rtl/nixie_shifter.sv
module nixie_shifter
    import nixie_pkg::*;
#(
    parameter int NUM_TUBES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [NUM_TUBES*CATHODES-1:0] frame_in,
    input  logic [NUM_TUBES-1:0]          tube_on_in,
    input  logic                          period_end,
    output logic                          run,
    output logic                          shifting,
    output logic                          sdo,
    output logic                          latch,
    output logic                          busy,
    output logic [NUM_TUBES-1:0]          tube_en
);
    localparam int FRAME_W = NUM_TUBES * CATHODES;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    ser_state_e           state;
    logic [FRAME_W-1:0]   shreg;
    logic [CNT_W-1:0]     bit_cnt;
    logic [NUM_TUBES-1:0] pend_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SER_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            pend_en <= '0;
            tube_en <= '0;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    if (load) begin
                        shreg   <= frame_in;
                        pend_en <= tube_on_in;
                        bit_cnt <= '0;
                        state   <= SER_SHIFT;
                    end
                end
                SER_SHIFT: begin
                    if (period_end) begin
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        if (bit_cnt == LAST_BIT) begin
                            state   <= SER_LATCH;
                            tube_en <= pend_en;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                SER_LATCH: begin
                    if (period_end) begin
                        state <= SER_IDLE;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    assign shifting = (state == SER_SHIFT);
    assign latch    = (state == SER_LATCH);
    assign run      = shifting || latch;
    assign busy     = run;
    assign sdo      = shreg[FRAME_W-1];

    AST_EN_ONLY_AT_LATCH: assert property (@(posedge clk) disable iff (rst)
        !$stable(tube_en) |-> $rose(latch)) else $error("enables moved outside latch"); // R5
    AST_LOAD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (shifting && load) |=> busy) else $error("load broke a frame"); // R9

endmodule

// File: rtl/nixie_frame_serializer.sv
module nixie_frame_serializer
    import nixie_pkg::*;
#(
    parameter int NUM_TUBES = 4,
    parameter int CLK_DIV   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_i,
    input  logic [NUM_TUBES*CODE_W-1:0] digits_i,
    output logic                        sclk_o,
    output logic                        sdo_o,
    output logic                        latch_o,
    output logic [NUM_TUBES-1:0]        tube_en_o,
    output logic                        busy_o
);
    localparam int FRAME_W = NUM_TUBES * CATHODES;

    logic [FRAME_W-1:0]   enc_frame;
    logic [NUM_TUBES-1:0] enc_on;
    logic                 run, shifting, period_end;

    nixie_frame_enc #(.NUM_TUBES(NUM_TUBES)) u_enc (
        .digits  (digits_i),
        .frame   (enc_frame),
        .tube_on (enc_on)
    );

    nixie_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .gate       (shifting),
        .sclk       (sclk_o),
        .period_end (period_end)
    );

    nixie_shifter #(.NUM_TUBES(NUM_TUBES)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load_i),
        .frame_in   (enc_frame),
        .tube_on_in (enc_on),
        .period_end (period_end),
        .run        (run),
        .shifting   (shifting),
        .sdo        (sdo_o),
        .latch      (latch_o),
        .busy       (busy_o),
        .tube_en    (tube_en_o)
    );

    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o)) else $error("data moved with clock high"); // R6
    AST_LATCH_NO_SCLK: assert property (@(posedge clk) disable iff (rst)
        latch_o |-> !sclk_o) else $error("clock during latch"); // R8
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && load_i) |=> busy_o) else $error("idle load not taken"); // R9

endmodule

// File: tb/nixie_frame_serializer_tb_top.sv
module nixie_frame_serializer_tb_top;

    localparam int NT  = 4;
    localparam int DIV = 4;
    localparam int FW  = NT * 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic [NT*4-1:0] digits = '0;
    logic          sclk_o, sdo_o, latch_o, busy_o;
    logic [NT-1:0] tube_en_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [FW-1:0] cap;
    int nbits, lat_cnt, hi_cnt, busy_cnt, overlap;

    always #2.5 clk = ~clk;

    nixie_frame_serializer #(.NUM_TUBES(NT), .CLK_DIV(DIV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .digits_i  (digits),
        .sclk_o    (sclk_o),
        .sdo_o     (sdo_o),
        .latch_o   (latch_o),
        .tube_en_o (tube_en_o),
        .busy_o    (busy_o)
    );

    always @(posedge sclk_o) begin
        cap   = {cap[FW-2:0], sdo_o};
        nbits = nbits + 1;
    end

    always @(negedge clk) begin
        if (busy_o)            busy_cnt = busy_cnt + 1;
        if (latch_o)           lat_cnt  = lat_cnt + 1;
        if (sclk_o)            hi_cnt   = hi_cnt + 1;
        if (latch_o && sclk_o) overlap  = overlap + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_field(input logic [3:0] c);
        if (c == 4'd10) return 10'd0;
        if (c == 4'd0 || c > 4'd9) return 10'b1000000000;
        return 10'd1 << (c - 4'd1);
    endfunction

    function automatic logic [FW-1:0] exp_frame(input logic [NT*4-1:0] d);
        logic [FW-1:0] f;
        for (int t = 0; t < NT; t++) f[FW-1-10*t -: 10] = exp_field(d[4*t +: 4]);
        return f;
    endfunction

    function automatic logic [NT-1:0] exp_en(input logic [NT*4-1:0] d);
        logic [NT-1:0] e;
        for (int t = 0; t < NT; t++) e[t] = (d[4*t +: 4] != 4'd10);
        return e;
    endfunction

    function automatic logic [15:0] pack(input int a, input int b, input int c, input int e);
        return {e[3:0], c[3:0], b[3:0], a[3:0]};
    endfunction

    // Sends one frame, optionally injects a second load mid-shift, checks everything.
    task automatic run_frame(input string req, input logic [15:0] d,
                             input bit inject, input logic [15:0] junk);
        logic [NT-1:0] prev_en;
        int guard;
        prev_en = tube_en_o;
        nbits = 0; lat_cnt = 0; hi_cnt = 0; busy_cnt = 0; overlap = 0; cap = '0;
        @(negedge clk); digits = d; load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after load", 64'(busy_o), 64'd1);
        repeat (DIV * 3) @(negedge clk);
        chk(tube_en_o == prev_en, "R5", "enables held mid-shift", 64'(tube_en_o), 64'(prev_en));
        if (inject) begin
            digits = junk; load = 1'b1;
            @(negedge clk); load = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 5000) begin
            @(negedge clk); guard++;
        end
        chk(cap == exp_frame(d), req, "serial frame", 64'(cap), 64'(exp_frame(d)));
        chk(nbits == FW, "R6", "bit count", 64'(nbits), 64'(FW));
        chk(hi_cnt == FW * DIV / 2, "R7", "sclk high cycles", 64'(hi_cnt), 64'(FW * DIV / 2));
        chk(lat_cnt == DIV && overlap == 0, "R8", "latch width/overlap",
            64'(lat_cnt), 64'(DIV));
        chk(busy_cnt == (FW + 1) * DIV, "R9", "busy width", 64'(busy_cnt), 64'((FW + 1) * DIV));
        chk(tube_en_o == exp_en(d), req, "tube enables", 64'(tube_en_o), 64'(exp_en(d)));
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({sclk_o, sdo_o, latch_o, busy_o} == 4'b0, "R10", "idle outputs",
            64'({sclk_o, sdo_o, latch_o, busy_o}), 64'd0);
        chk(tube_en_o == '0, "R10", "enables off", 64'(tube_en_o), 64'd0);
        repeat (DIV * 2) @(negedge clk);
        chk(sclk_o == 1'b0, "R7", "clock idles low", 64'(sclk_o), 64'd0);
    endtask

    task automatic test_digits();
        run_frame("R1", pack(0, 1, 2, 3), 1'b0, '0);
        run_frame("R2", pack(9, 8, 5, 4), 1'b0, '0);
        run_frame("R2", pack(7, 6, 0, 9), 1'b0, '0);
    endtask

    task automatic test_blank();
        run_frame("R3", pack(10, 7, 10, 1), 1'b0, '0);
        run_frame("R3", pack(10, 10, 10, 10), 1'b0, '0);
    endtask

    task automatic test_range();
        run_frame("R4", pack(11, 15, 12, 9), 1'b0, '0);
        run_frame("R4", pack(13, 14, 10, 3), 1'b0, '0);
    endtask

    task automatic test_busy_ignore();
        run_frame("R9", pack(5, 6, 7, 8), 1'b1, pack(10, 10, 10, 10));
        run_frame("R5", pack(1, 10, 2, 10), 1'b0, '0);
    endtask

    initial begin
        test_reset();
        test_digits();
        test_blank();
        test_range();
        test_busy_ignore();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule